// File: doc/BRIEF.md
# Inbound DMA Address Translation Unit

This block converts an address arriving from the I/O bus side of a DMA path into a system memory address. Each lookup first decodes the address into one of five windows. Two windows need no table. The 64-bit direct window passes the low address bits through. The 32-bit direct window joins a per-port upper-address register with the low 30 address bits. The other three windows index page translation tables: a shared table whose page size can be programmed, a dedicated wide table with 64 MB pages, and the shared table again, read as 16 GB super-pages.

A simple write port loads the table entries, the per-port upper-address registers and the shared-table page shift. Every lookup returns a registered result one cycle later. The result carries the translated address, a success pulse or an error pulse, the decoded window and the barrier attribute that was removed from the address.

Top module: `dma_xlate_unit`

## Requirements
- R1: A lookup presented with `req_valid_i` high at a rising edge produces, at that edge, exactly one of `rsp_valid_o` or `rsp_err_o` for one cycle. With no lookup, both are low after the next edge.
- R2: Window codes on `rsp_win_o` are: 0 none, 1 direct-64, 2 direct-32, 3 shared-table, 4 wide-table, 5 super-page. Decode order:
  - bit 63 set selects direct-64.
  - Otherwise bits 62:40 must be zero. Bit 39 set selects super-page.
  - Otherwise bit 38 set selects wide-table.
  - Otherwise bits 37:32 zero with bit 31 set selects direct-32, and bits 37:32 zero with bit 31 clear selects shared-table.
  - Any other address selects none, which is an error.
- R3: Direct-64 returns address bits 53:0 with bits 63:54 zero. The barrier output is address bit 62.
- R4: Direct-32 returns bits 63:30 of the upper-address register of port `req_port_i`, joined with address bits 29:0. The barrier output is address bit 30.
- R5: Shared-table lookups clear bit 30 (the barrier, reported on `rsp_barrier_o`). The table index is the remaining offset shifted right by the page shift, and the in-page offset is the low page-shift bits.
- R6: The page shift is written from `cfg_data_i[5:0]`. A value below 12 is stored as 12, and a value above 30 is stored as 30.
- R7: Wide-table lookups use offset bits 37:0, 64 MB pages (shift 26) and the wide table. The barrier output is 0.
- R8: Super-page lookups use offset bits 38:0, 16 GB pages (shift 34) and the shared table. The barrier output is 0.
- R9: A table entry is valid when bit 63 is set. The result is entry bits 62:shift joined with the in-page offset, so entry bits below the page shift are ignored.
- R10: Any of the following gives `rsp_err_o` with `rsp_addr_o` zero:
  - an invalid entry;
  - a table index at or past the table depth;
  - an undecoded address.
- R11: Config writes use `cfg_sel_i`: 0 shared entry, 1 wide entry, 2 upper-address register (index = port), 3 page shift. A write at an edge affects lookups at later edges only. A lookup at the same edge sees the old contents.
- R12: Reset clears all table entries and both upper-address registers, and sets the page shift to 18 (256 KB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Lookup request |
| req_addr_i | input | 64 | Bus-side address |
| req_port_i | input | PORT_W | Requesting port, selects upper-address register |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_sel_i | input | 2 | Config target select |
| cfg_idx_i | input | CFG_IDX_W | Entry or port index |
| cfg_data_i | input | 64 | Config write data |
| rsp_valid_o | output | 1 | Successful translation pulse |
| rsp_err_o | output | 1 | Failed translation pulse |
| rsp_addr_o | output | 64 | Translated system address, zero on error |
| rsp_win_o | output | 3 | Decoded window code |
| rsp_barrier_o | output | 1 | Barrier attribute taken from the address |

## Verification
The assertions assume that `req_valid_i` is a clean, fully driven level sampled at each edge. They also assume `req_addr_i` is stable across that edge, because the direct-32 property compares result bits with the previous cycle's address. The bench drives every request and config write on the falling edge and samples on the following falling edge, so inputs never change near a rising edge. Page-shift values outside 12..30 are written on purpose, but table entries are always written page-aligned, apart from deliberate low-bit junk used to exercise R9.

// File: rtl/dxu_pkg.sv
package dxu_pkg;
  localparam int unsigned ADDR_W      = 64;
  localparam int unsigned SHIFT_W     = 6;
  localparam int unsigned D64_KEEP    = 54;
  localparam int unsigned D32_SPLIT   = 30;
  localparam int unsigned WIDE_SHIFT  = 26;
  localparam int unsigned SUPER_SHIFT = 34;
  localparam logic [SHIFT_W-1:0] PG_SHIFT_RST = 6'd18;
  localparam logic [SHIFT_W-1:0] PG_SHIFT_MIN = 6'd12;
  localparam logic [SHIFT_W-1:0] PG_SHIFT_MAX = 6'd30;

  typedef enum logic [2:0] {
    WIN_NONE  = 3'd0,
    WIN_D64   = 3'd1,
    WIN_D32   = 3'd2,
    WIN_M32   = 3'd3,
    WIN_WIDE  = 3'd4,
    WIN_SUPER = 3'd5
  } win_e;

  typedef enum logic [1:0] {
    CFG_SHARED  = 2'd0,
    CFG_WIDE    = 2'd1,
    CFG_DIRMAP  = 2'd2,
    CFG_PGSHIFT = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    win_e              win;
    logic              barrier;
    logic [ADDR_W-1:0] off;
  } dec_t;
endpackage

// File: rtl/dxu_decode.sv
module dxu_decode
  import dxu_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  logic unused_msi_rsvd;
  assign unused_msi_rsvd = ^addr_i[61:D64_KEEP];

  always_comb begin
    dec_o.win     = WIN_NONE;
    dec_o.barrier = 1'b0;
    dec_o.off     = '0;
    if (addr_i[63]) begin
      dec_o.win     = WIN_D64;
      dec_o.barrier = addr_i[62];
      dec_o.off     = ADDR_W'(addr_i[D64_KEEP-1:0]);
    end else if (addr_i[62:40] == '0) begin
      if (addr_i[39]) begin
        dec_o.win = WIN_SUPER;
        dec_o.off = ADDR_W'(addr_i[38:0]);
      end else if (addr_i[38]) begin
        dec_o.win = WIN_WIDE;
        dec_o.off = ADDR_W'(addr_i[37:0]);
      end else if (addr_i[37:32] == '0) begin
        // both 32-bit windows carry the barrier in bit 30, excluded from offset
        dec_o.win     = addr_i[31] ? WIN_D32 : WIN_M32;
        dec_o.barrier = addr_i[D32_SPLIT];
        dec_o.off     = ADDR_W'(addr_i[D32_SPLIT-1:0]);
      end
    end
  end
endmodule

// File: rtl/dxu_entry_table.sv
module dxu_entry_table
  import dxu_pkg::*;
#(
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned CFG_IDX_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [CFG_IDX_W-1:0] widx_i,
  input  logic [ADDR_W-1:0]    wdata_i,
  input  logic [ADDR_W-1:0]    ridx_i,
  output logic [ADDR_W-1:0]    rdata_o,
  output logic                 hit_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] mem_q [DEPTH];
  logic              w_in_range;
  logic              r_in_range;

  assign w_in_range = ADDR_W'(widx_i) < ADDR_W'(DEPTH);
  assign r_in_range = ridx_i < ADDR_W'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && w_in_range) begin
      mem_q[widx_i[AW-1:0]] <= wdata_i;
    end
  end

  assign rdata_o = r_in_range ? mem_q[ridx_i[AW-1:0]] : '0;
  assign hit_o   = r_in_range && rdata_o[ADDR_W-1];
endmodule

// File: rtl/dxu_cfg_regs.sv
module dxu_cfg_regs
  import dxu_pkg::*;
#(
  parameter int unsigned PORT_W    = 1,
  parameter int unsigned CFG_IDX_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [1:0]                sel_i,
  input  logic [CFG_IDX_W-1:0]      idx_i,
  input  logic [ADDR_W-1:0]         data_i,
  input  logic [PORT_W-1:0]         port_i,
  output logic [ADDR_W-D32_SPLIT-1:0] dirmap_o,
  output logic [SHIFT_W-1:0]        pg_shift_o
);
  localparam int unsigned NUM_PORTS = 2 ** PORT_W;
  localparam int unsigned UPPER_W   = ADDR_W - D32_SPLIT;

  logic [UPPER_W-1:0] dirmap_q [NUM_PORTS];
  logic [SHIFT_W-1:0] shift_q;
  logic [SHIFT_W-1:0] shift_d;
  logic               unused_data;

  assign unused_data = ^data_i[D32_SPLIT-1:SHIFT_W];

  always_comb begin
    shift_d = data_i[SHIFT_W-1:0];
    if (shift_d < PG_SHIFT_MIN) shift_d = PG_SHIFT_MIN;
    if (shift_d > PG_SHIFT_MAX) shift_d = PG_SHIFT_MAX;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dirmap_q[p] <= '0;
      else if (we_i && sel_i == CFG_DIRMAP && ADDR_W'(idx_i) == ADDR_W'(p))
        dirmap_q[p] <= data_i[ADDR_W-1:D32_SPLIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_q <= PG_SHIFT_RST;
    else if (we_i && sel_i == CFG_PGSHIFT) shift_q <= shift_d;
  end

  assign dirmap_o   = dirmap_q[port_i];
  assign pg_shift_o = shift_q;
endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit
  import dxu_pkg::*;
#(
  parameter int unsigned SHARED_DEPTH = 128,
  parameter int unsigned WIDE_DEPTH   = 64,
  parameter int unsigned PORT_W       = 1,
  parameter int unsigned CFG_IDX_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [63:0]          req_addr_i,
  input  logic [PORT_W-1:0]    req_port_i,
  input  logic                 cfg_we_i,
  input  logic [1:0]           cfg_sel_i,
  input  logic [CFG_IDX_W-1:0] cfg_idx_i,
  input  logic [63:0]          cfg_data_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_err_o,
  output logic [63:0]          rsp_addr_o,
  output logic [2:0]           rsp_win_o,
  output logic                 rsp_barrier_o
);
  localparam int unsigned UPPER_W = ADDR_W - D32_SPLIT;

  dec_t               dec;
  logic [UPPER_W-1:0] dirmap;
  logic [SHIFT_W-1:0] pg_shift;
  logic [SHIFT_W-1:0] sh;
  logic [ADDR_W-1:0]  page_mask;
  logic [ADDR_W-1:0]  shared_ridx, wide_ridx;
  logic [ADDR_W-1:0]  shared_ent, wide_ent, entry;
  logic               shared_hit, wide_hit, ent_hit;
  logic               is_table, err;
  logic [ADDR_W-1:0]  xlate;

  dxu_decode u_dec (
    .addr_i (req_addr_i),
    .dec_o  (dec)
  );

  dxu_cfg_regs #(.PORT_W(PORT_W), .CFG_IDX_W(CFG_IDX_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .sel_i      (cfg_sel_i),
    .idx_i      (cfg_idx_i),
    .data_i     (cfg_data_i),
    .port_i     (req_port_i),
    .dirmap_o   (dirmap),
    .pg_shift_o (pg_shift)
  );

  assign shared_ridx = (dec.win == WIN_SUPER) ? (dec.off >> SUPER_SHIFT)
                                              : (dec.off >> pg_shift);
  assign wide_ridx   = dec.off >> WIDE_SHIFT;

  dxu_entry_table #(.DEPTH(SHARED_DEPTH), .CFG_IDX_W(CFG_IDX_W)) u_shared (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i && cfg_sel_i == CFG_SHARED),
    .widx_i  (cfg_idx_i),
    .wdata_i (cfg_data_i),
    .ridx_i  (shared_ridx),
    .rdata_o (shared_ent),
    .hit_o   (shared_hit)
  );

  dxu_entry_table #(.DEPTH(WIDE_DEPTH), .CFG_IDX_W(CFG_IDX_W)) u_wide (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i && cfg_sel_i == CFG_WIDE),
    .widx_i  (cfg_idx_i),
    .wdata_i (cfg_data_i),
    .ridx_i  (wide_ridx),
    .rdata_o (wide_ent),
    .hit_o   (wide_hit)
  );

  always_comb begin
    unique case (dec.win)
      WIN_WIDE:  sh = SHIFT_W'(WIDE_SHIFT);
      WIN_SUPER: sh = SHIFT_W'(SUPER_SHIFT);
      default:   sh = pg_shift;
    endcase
  end

  assign page_mask = ~({ADDR_W{1'b1}} << sh);
  assign entry     = (dec.win == WIN_WIDE) ? wide_ent : shared_ent;
  assign ent_hit   = (dec.win == WIN_WIDE) ? wide_hit : shared_hit;
  assign is_table  = dec.win inside {WIN_M32, WIN_WIDE, WIN_SUPER};
  assign err       = (dec.win == WIN_NONE) || (is_table && !ent_hit);

  always_comb begin
    unique case (dec.win)
      WIN_D64: xlate = dec.off;
      WIN_D32: xlate = {dirmap, dec.off[D32_SPLIT-1:0]};
      WIN_M32, WIN_WIDE, WIN_SUPER:
        xlate = ({1'b0, entry[ADDR_W-2:0]} & ~page_mask) | (dec.off & page_mask);
      default: xlate = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_err_o     <= 1'b0;
      rsp_addr_o    <= '0;
      rsp_win_o     <= WIN_NONE;
      rsp_barrier_o <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i && !err;
      rsp_err_o   <= req_valid_i && err;
      if (req_valid_i) begin
        rsp_addr_o    <= err ? '0 : xlate;
        rsp_win_o     <= dec.win;
        rsp_barrier_o <= dec.barrier;
      end
    end
  end
endmodule

// File: rtl/dxu_checker.sv
module dxu_checker
  import dxu_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [63:0] req_addr_i,
  input logic        rsp_valid_o,
  input logic        rsp_err_o,
  input logic [63:0] rsp_addr_o,
  input logic [2:0]  rsp_win_o,
  input logic        rsp_barrier_o
);
  logic unused_hi;
  assign unused_hi = ^req_addr_i[63:30];

  // R1
  rsp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && rsp_err_o));
  // R1
  rsp_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || rsp_err_o) |-> $past(req_valid_i));
  // R1
  req_gets_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_valid_o || rsp_err_o));
  // R10
  err_addr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_addr_o == '0));
  // R2
  none_not_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_win_o != WIN_NONE));
  // R8
  wide_no_barrier_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && (rsp_win_o == WIN_WIDE || rsp_win_o == WIN_SUPER)) |-> !rsp_barrier_o);
  // R3
  d64_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_win_o == WIN_D64) |-> (rsp_addr_o[63:54] == '0));
  // R4
  d32_low_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_win_o == WIN_D32) |-> (rsp_addr_o[29:0] == $past(req_addr_i[29:0])));
endmodule

bind dma_xlate_unit dxu_checker u_dxu_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_addr_i    (req_addr_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_err_o     (rsp_err_o),
  .rsp_addr_o    (rsp_addr_o),
  .rsp_win_o     (rsp_win_o),
  .rsp_barrier_o (rsp_barrier_o)
);

// File: tb/dma_xlate_unit_test.sv
module dma_xlate_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic [0:0]  req_port = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_idx = '0;
  logic [63:0] cfg_data = '0;
  logic        rsp_valid, rsp_err, rsp_barrier;
  logic [63:0] rsp_addr;
  logic [2:0]  rsp_win;

  int n_cmp = 0;
  int n_bad = 0;
  localparam logic [63:0] V = 64'h8000_0000_0000_0000;

  always #4 clk = ~clk;

  dma_xlate_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_port_i(req_port), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_idx_i(cfg_idx),
    .cfg_data_i(cfg_data), .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
    .rsp_addr_o(rsp_addr), .rsp_win_o(rsp_win), .rsp_barrier_o(rsp_barrier)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input logic [7:0] idx, input logic [63:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input logic [63:0] a, input logic p);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_port = p;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_ok(input string tag, input logic [63:0] a, input logic p,
                           input logic [63:0] ea, input logic [2:0] ew, input logic eb);
    lookup(a, p);
    chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " err"}, 64'(rsp_err), 64'd0);
    chk({tag, " addr"}, rsp_addr, ea);
    chk({tag, " win"}, 64'(rsp_win), 64'(ew));
    chk({tag, " barrier"}, 64'(rsp_barrier), 64'(eb));
  endtask

  task automatic expect_err(input string tag, input logic [63:0] a, input logic p,
                            input logic [2:0] ew);
    lookup(a, p);
    chk({tag, " valid"}, 64'(rsp_valid), 64'd0);
    chk({tag, " err"}, 64'(rsp_err), 64'd1);
    chk({tag, " addr"}, rsp_addr, 64'd0);
    chk({tag, " win"}, 64'(rsp_win), 64'(ew));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_idle();
    chk("R12 reset valid", 64'(rsp_valid), 64'd0);
    chk("R12 reset err", 64'(rsp_err), 64'd0);
    expect_err("R12 cleared shared entry", 64'h0000_0000_0000_0100, 1'b0, 3'd3);
    @(negedge clk);
    chk("R1 idle valid", 64'(rsp_valid), 64'd0);
    chk("R1 idle err", 64'(rsp_err), 64'd0);
  endtask

  task automatic t_direct64();
    expect_ok("R3 d64 all ones", 64'hE0FF_FFFF_FFFF_FFFF, 1'b0, 64'h003F_FFFF_FFFF_FFFF, 3'd1, 1'b1);
    expect_ok("R3 d64 plain", 64'h8000_0000_0000_1000, 1'b1, 64'h0000_0000_0000_1000, 3'd1, 1'b0);
  endtask

  task automatic t_direct32();
    cfg_wr(2'd2, 8'd1, 64'h0000_0123_C000_0000);
    expect_ok("R4 d32 port1", 64'h0000_0000_C123_4567, 1'b1, 64'h0000_0123_C123_4567, 3'd2, 1'b1);
    expect_ok("R4 d32 port0", 64'h0000_0000_8123_4567, 1'b0, 64'h0000_0000_0123_4567, 3'd2, 1'b0);
  endtask

  task automatic t_shared_pages();
    // entry with junk below the page shift (R9)
    cfg_wr(2'd0, 8'd3, V | 64'h0000_0012_3400_0000 | 64'h2_5555);
    expect_ok("R5 R9 m32 256K", 64'h0000_0000_400C_1ABC, 1'b0, 64'h0000_0012_3400_1ABC, 3'd3, 1'b1);
    cfg_wr(2'd3, 8'd0, 64'd20);
    expect_ok("R6 m32 1M", 64'h0000_0000_0030_0010, 1'b0, 64'h0000_0012_3400_0010, 3'd3, 1'b0);
    cfg_wr(2'd0, 8'd0, V | 64'h0000_0040_0000_0000);
    cfg_wr(2'd3, 8'd0, 64'd40);
    expect_ok("R6 clamp high", 64'h0000_0000_2345_6789, 1'b0, 64'h0000_0040_2345_6789, 3'd3, 1'b0);
    cfg_wr(2'd0, 8'd1, V | 64'h0000_0007_0000_0000);
    cfg_wr(2'd3, 8'd0, 64'd3);
    expect_ok("R6 clamp low", 64'h0000_0000_0000_1005, 1'b0, 64'h0000_0007_0000_0005, 3'd3, 1'b0);
    cfg_wr(2'd3, 8'd0, 64'd18);
    expect_err("R10 m32 index past end", 64'h0000_0000_3000_0000, 1'b0, 3'd3);
    expect_err("R10 m32 invalid entry", 64'h0000_0000_0028_0000, 1'b0, 3'd3);
  endtask

  task automatic t_wide();
    cfg_wr(2'd1, 8'd17, V | 64'h0000_0005_0000_0000);
    expect_ok("R7 wide", 64'h0000_0040_4412_3456, 1'b0, 64'h0000_0005_0012_3456, 3'd4, 1'b0);
    expect_err("R10 wide index past end", 64'h0000_0041_0000_0000, 1'b0, 3'd4);
  endtask

  task automatic t_super();
    cfg_wr(2'd0, 8'd2, V | 64'h0000_001C_0000_0000);
    expect_ok("R8 super", 64'h0000_0089_6345_6789, 1'b1, 64'h0000_001D_6345_6789, 3'd5, 1'b0);
  endtask

  task automatic t_unmapped();
    expect_err("R2 R10 gap", 64'h0000_0001_0000_0000, 1'b0, 3'd0);
    expect_err("R2 R10 above 40b", 64'h0000_0100_0000_0000, 1'b0, 3'd0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_idx = 8'd20; cfg_data = V | 64'h0000_0009_0000_0000;
    req_valid = 1'b1; req_addr = 64'h0000_0000_0050_0000; req_port = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R11 same-edge sees old err", 64'(rsp_err), 64'd1);
    chk("R11 same-edge sees old valid", 64'(rsp_valid), 64'd0);
    expect_ok("R11 later lookup sees new", 64'h0000_0000_0050_0000, 1'b0,
              64'h0000_0009_0000_0000, 3'd3, 1'b0);
  endtask

  task automatic t_reset_clears();
    cfg_wr(2'd3, 8'd0, 64'd20);
    do_reset();
    expect_err("R12 entry cleared", 64'h0000_0000_400C_1ABC, 1'b0, 3'd3);
    expect_ok("R12 dirmap cleared", 64'h0000_0000_C123_4567, 1'b1, 64'h0000_0000_0123_4567, 3'd2, 1'b1);
    cfg_wr(2'd0, 8'd3, V | 64'h0000_0012_3400_0000);
    expect_ok("R12 shift back to 18", 64'h0000_0000_400C_1ABC, 1'b0, 64'h0000_0012_3400_1ABC, 3'd3, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_direct64();
    t_direct32();
    t_shared_pages();
    t_wide();
    t_super();
    t_unmapped();
    t_same_cycle();
    t_reset_clears();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule